// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This controller sits on the host side of a parallel NOR flash. Once a program or erase sequence has been issued elsewhere, a single `start` pulse hands the operation address, the expected data word and an iteration budget to the poller. It then reads device status through a simple request/acknowledge read port until the embedded algorithm has finished. Two methods can be chosen per operation. The first compares the data-complement bit with the expected data. The second watches whether the toggle bit keeps flipping between two consecutive reads.

The device can raise its exceeded-time flag in the same read where the completion bit settles. For this reason the poller never turns that flag directly into a failure. It always takes one more look at the completion indication first. On any failure, including an exhausted iteration budget, it writes the reset command to the device so that the flash returns to array-read mode. Only after that write does it report. The result is a one-cycle `done` pulse with `pass` valid in the same cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: `start` is accepted only while the poller is idle. A `start` during an operation causes no extra read, no extra write and no extra `done`.
- R2: Each status read holds `rd_req` high until `rd_ack`, samples `rd_data` in the acknowledge cycle, and drives `rd_addr` with the address captured at `start`. `rd_req` is low for at least one cycle between two reads.
- R3: Data mode (`mode`=0): when status bit 7 equals bit 7 of the captured expected data, the operation ends with pass, whatever bit 5 shows.
- R4: Data mode: when bit 7 differs and bit 5 (exceeded-time flag) is 0, another status read follows.
- R5: Data mode: when bit 7 differs and bit 5 is 1, exactly one more read is made. Bit 7 matching there gives pass; a mismatch gives fail.
- R6: Toggle mode (`mode`=1): each iteration is two reads. If bit 6 has the same value in both, the result is pass.
- R7: Toggle mode: if bit 6 differs and bit 5 of the second read is 0, a new pair of reads follows.
- R8: Toggle mode: if bit 6 differs and bit 5 of the second read is 1, one more pair is read. Bit 6 still differing within that pair gives fail; otherwise the result is pass.
- R9: Iterations are counted from 1. An iteration that would repeat while the count is already at least `max_iter` ends in fail instead, so `max_iter` values 0 and 1 both allow a single iteration.
- R10: Every fail issues exactly one write of the reset command 0xF0 (zero-extended) to the operation address, held until `wr_ack`, before `done`. A pass issues no write.
- R11: `done` is a single-cycle pulse and `pass` is high only together with it. After reset `done`, `rd_req` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling one operation |
| mode | input | 1 | 0 = data-bit compare, 1 = toggle detect |
| op_addr | input | ADDR_W | Address used for status reads and the reset write |
| exp_data | input | DATA_W | Data that was programmed; bit 7 is compared |
| max_iter | input | ITER_W | Iteration budget |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_addr | output | ADDR_W | Status read address |
| rd_ack | input | 1 | Read acknowledge, data valid in this cycle |
| rd_data | input | DATA_W | Status word; bits 7, 6 and 5 are used |
| wr_req | output | 1 | Reset-command write request |
| wr_addr | output | ADDR_W | Reset write address |
| wr_data | output | DATA_W | Reset command value |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid while `done` is high |

## Verification
The bench goes after the read in which the exceeded-time flag appears. A poller that trusted the flag alone would report fail where the re-check read passes, or would stop one read short. When bit 7 already matches in that same read, the bench expects an immediate pass. A design that let the flag win would report fail there. In toggle mode the bench also has a pair straddle two iterations. A poller that compared across pairs, or read the flag from the wrong read, would miscount reads or flip the result. A `start` is pulsed while busy, and the iteration budget is set to 0 and to small values, to expose a second launched operation and off-by-one budgets.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
   // status bit positions decoded by the poller
   localparam int BIT_DONE = 7;
   localparam int BIT_TGL  = 6;
   localparam int BIT_TO   = 5;

   typedef enum logic [2:0] {
      STG_POLL,
      STG_RECHK,
      STG_TA,
      STG_TB,
      STG_TC,
      STG_TD
   } stage_e;

   typedef enum logic [1:0] {
      ACT_NEXT,
      ACT_PASS,
      ACT_FAIL
   } act_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_READ,
      PH_WRITE
   } phase_e;
endpackage

// File: rtl/fpoll_read_port.sv
module fpoll_read_port
   import fpoll_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic              rsp_valid,
   output logic [2:0]        rsp_stat
);
   logic unused_low;
   assign unused_low = ^rd_data[BIT_TO-1:0];

   generate
      if (DATA_W > 8) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^rd_data[DATA_W-1:8];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_stat  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (rd_req && rd_ack) begin
            rd_req    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_stat  <= {rd_data[BIT_DONE], rd_data[BIT_TGL], rd_data[BIT_TO]};
         end else if (go) begin
            rd_req <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpoll_iter_cnt.sv
module fpoll_iter_cnt #(
   parameter int ITER_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [ITER_W-1:0] limit,
   output logic              at_limit
);
   localparam logic [ITER_W-1:0] ONE = ITER_W'(1);

   logic [ITER_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= ONE;
      else if (clr)
         cnt <= ONE;
      else if (inc)
         cnt <= cnt + ONE;
   end

   assign at_limit = (cnt >= limit);
endmodule

// File: rtl/fpoll_decide.sv
module fpoll_decide
   import fpoll_pkg::*;
(
   input  stage_e     stage,
   input  logic [2:0] stat,
   input  logic       exp_bit,
   input  logic       ref_bit,
   input  logic       at_limit,
   output act_e       act,
   output stage_e     nxt_stage,
   output logic       cnt_inc
);
   logic s_done, s_tgl, s_to;
   assign s_done = stat[2];
   assign s_tgl  = stat[1];
   assign s_to   = stat[0];

   always_comb begin
      act       = ACT_FAIL;
      nxt_stage = stage;
      cnt_inc   = 1'b0;
      unique case (stage)
         STG_POLL: begin
            if (s_done == exp_bit)
               act = ACT_PASS;
            else if (s_to) begin
               act       = ACT_NEXT;
               nxt_stage = STG_RECHK;
            end else if (!at_limit) begin
               act       = ACT_NEXT;
               nxt_stage = STG_POLL;
               cnt_inc   = 1'b1;
            end
         end
         STG_RECHK:
            act = (s_done == exp_bit) ? ACT_PASS : ACT_FAIL;
         STG_TA, STG_TC: begin
            act       = ACT_NEXT;
            nxt_stage = (stage == STG_TA) ? STG_TB : STG_TD;
         end
         STG_TB: begin
            if (s_tgl == ref_bit)
               act = ACT_PASS;
            else if (s_to) begin
               act       = ACT_NEXT;
               nxt_stage = STG_TC;
            end else if (!at_limit) begin
               act       = ACT_NEXT;
               nxt_stage = STG_TA;
               cnt_inc   = 1'b1;
            end
         end
         STG_TD:
            act = (s_tgl == ref_bit) ? ACT_PASS : ACT_FAIL;
         default: act = ACT_FAIL;
      endcase
   end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
   import fpoll_pkg::*;
#(
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 20,
   parameter int          ITER_W    = 8,
   parameter logic [7:0]  RESET_CMD = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] exp_data,
   input  logic [ITER_W-1:0] max_iter,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              done,
   output logic              pass
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("flash_poll_ctrl: DATA_W must be at least 8");
      end
      if (ADDR_W < 1 || ITER_W < 1) begin : g_bad_w
         $error("flash_poll_ctrl: ADDR_W and ITER_W must be positive");
      end
      if (DATA_W > 8) begin : g_exp_wide
         logic unused_exp_hi;
         assign unused_exp_hi = ^exp_data[DATA_W-1:8];
      end
   endgenerate

   logic unused_exp_lo;
   assign unused_exp_lo = ^exp_data[BIT_DONE-1:0];

   phase_e            phase;
   stage_e            stage;
   logic [ADDR_W-1:0] addr_q;
   logic [ITER_W-1:0] lim_q;
   logic              exp_q;
   logic              ref_q;

   logic       go;
   logic       rsp_valid;
   logic [2:0] rsp_stat;
   logic       at_limit;
   act_e       act;
   stage_e     nxt_stage;
   logic       cnt_inc;
   logic       launch;
   logic       step;

   assign launch = (phase == PH_IDLE) && start;
   assign step   = (phase == PH_READ) && rsp_valid;
   assign go     = launch || (step && act == ACT_NEXT);

   fpoll_read_port #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .rd_ack    (rd_ack),
      .rd_data   (rd_data),
      .rd_req    (rd_req),
      .rsp_valid (rsp_valid),
      .rsp_stat  (rsp_stat)
   );

   fpoll_iter_cnt #(.ITER_W(ITER_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (launch),
      .inc      (step && act == ACT_NEXT && cnt_inc),
      .limit    (lim_q),
      .at_limit (at_limit)
   );

   fpoll_decide u_dec (
      .stage     (stage),
      .stat      (rsp_stat),
      .exp_bit   (exp_q),
      .ref_bit   (ref_q),
      .at_limit  (at_limit),
      .act       (act),
      .nxt_stage (nxt_stage),
      .cnt_inc   (cnt_inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         stage  <= STG_POLL;
         addr_q <= '0;
         lim_q  <= '0;
         exp_q  <= 1'b0;
         ref_q  <= 1'b0;
         done   <= 1'b0;
         pass   <= 1'b0;
      end else begin
         done <= 1'b0;
         pass <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  addr_q <= op_addr;
                  lim_q  <= max_iter;
                  exp_q  <= exp_data[BIT_DONE];
                  stage  <= mode ? STG_TA : STG_POLL;
                  phase  <= PH_READ;
               end
            end
            PH_READ: begin
               if (rsp_valid) begin
                  if (stage == STG_TA || stage == STG_TC)
                     ref_q <= rsp_stat[1];
                  unique case (act)
                     ACT_NEXT: stage <= nxt_stage;
                     ACT_PASS: begin
                        done  <= 1'b1;
                        pass  <= 1'b1;
                        phase <= PH_IDLE;
                     end
                     default: phase <= PH_WRITE;
                  endcase
               end
            end
            PH_WRITE: begin
               if (wr_ack) begin
                  done  <= 1'b1;
                  phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign rd_addr = addr_q;
   assign wr_addr = addr_q;
   assign wr_req  = (phase == PH_WRITE);
   assign wr_data = DATA_W'(RESET_CMD);
endmodule

// File: rtl/fpoll_ctrl_chk.sv
module fpoll_ctrl_chk #(
   parameter int         DATA_W    = 16,
   parameter logic [7:0] RESET_CMD = 8'hF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_ack,
   input logic              wr_req,
   input logic              wr_ack,
   input logic [DATA_W-1:0] wr_data,
   input logic              done,
   input logic              pass
);
   a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req);

   a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_ack |=> !rd_req);

   a_r10_cmd_value: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> wr_data == DATA_W'(RESET_CMD));

   a_r10_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !wr_ack |=> wr_req);

   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   a_r10_fail_wrote: assert property (@(posedge clk) disable iff (!rst_n)
      done && !pass |-> $past(wr_req && wr_ack));

   a_r10_pass_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      done && pass |-> !$past(wr_req));

   a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done);
endmodule

bind flash_poll_ctrl fpoll_ctrl_chk #(
   .DATA_W    (DATA_W),
   .RESET_CMD (RESET_CMD)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_req  (rd_req),
   .rd_ack  (rd_ack),
   .wr_req  (wr_req),
   .wr_ack  (wr_ack),
   .wr_data (wr_data),
   .done    (done),
   .pass    (pass)
);

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 20;
   localparam int ITER_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              mode = 1'b0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic [DATA_W-1:0] exp_data = '0;
   logic [ITER_W-1:0] max_iter = '0;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_ack = 1'b0;
   logic [DATA_W-1:0] rd_data = '0;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              wr_ack = 1'b0;
   logic              done;
   logic              pass;

   always #10 clk = ~clk;

   flash_poll_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ITER_W(ITER_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_addr(op_addr),
      .exp_data(exp_data), .max_iter(max_iter), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ack(wr_ack), .done(done), .pass(pass)
   );

   logic [7:0] scr [64];
   int n_checks = 0;
   int n_fail   = 0;
   int rd_ptr   = 0;
   int wr_cnt   = 0;
   int done_cnt = 0;
   int addr_err = 0;
   bit last_pass = 1'b0;
   logic [DATA_W-1:0] last_wr_data = '0;

   task automatic check(input string tag, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // flash responder: status reads from the script, write acknowledge
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            done_cnt++;
            last_pass = pass;
         end
         if (rd_req && !rd_ack) begin
            rd_ack  = 1'b1;
            rd_data = {8'h00, scr[rd_ptr]};
            if (rd_addr != op_addr) addr_err++;
            if (rd_ptr < 63) rd_ptr++;
         end else begin
            rd_ack = 1'b0;
         end
         if (wr_req && !wr_ack) begin
            wr_ack = 1'b1;
            last_wr_data = wr_data;
            if (wr_addr != op_addr) addr_err++;
            wr_cnt++;
         end else begin
            wr_ack = 1'b0;
         end
      end
   end

   function automatic void fill_busy(input bit e7);
      for (int i = 0; i < 64; i++) scr[i] = {~e7, i[0], 6'b0};
   endfunction

   function automatic void setb(input int i, input bit b7, input bit b6, input bit b5);
      scr[i] = {b7, b6, b5, 5'b0};
   endfunction

   function automatic void model(input bit md, input bit e7, input int lim,
                                 output int nr, output bit ok);
      int i = 0;
      int it = 1;
      bit fin = 0;
      logic [7:0] a, b;
      ok = 0;
      while (!fin && i < 56) begin
         if (!md) begin
            a = scr[i]; i++;
            if (a[7] == e7) begin ok = 1; fin = 1; end
            else if (a[5]) begin ok = (scr[i][7] == e7); i++; fin = 1; end
            else if (it >= lim) begin ok = 0; fin = 1; end
            else it++;
         end else begin
            a = scr[i]; b = scr[i+1]; i += 2;
            if (a[6] == b[6]) begin ok = 1; fin = 1; end
            else if (b[5]) begin ok = (scr[i][6] == scr[i+1][6]); i += 2; fin = 1; end
            else if (it >= lim) begin ok = 0; fin = 1; end
            else it++;
         end
      end
      nr = i;
   endfunction

   int case_no = 0;

   task automatic run_case(input string tag, input bit md, input bit e7, input int lim,
                           input bit extra_start);
      int nr;
      bit ok;
      int wait_cyc;
      model(md, e7, lim, nr, ok);
      case_no++;
      @(negedge clk);
      rd_ptr = 0; wr_cnt = 0; done_cnt = 0; addr_err = 0;
      mode = md;
      exp_data = {8'h5A, e7, 7'h33};
      max_iter = ITER_W'(lim);
      op_addr = ADDR_W'(case_no * 4099 + 17);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (extra_start) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_cyc = 0;
      while (done_cnt == 0 && wait_cyc < 2000) begin
         @(negedge clk);
         wait_cyc++;
      end
      repeat (8) @(negedge clk);
      check(tag, "pass result", int'(last_pass), int'(ok));
      check(tag, "read count", rd_ptr, nr);
      check("R10", "reset writes", wr_cnt, ok ? 0 : 1);
      check("R2", "address errors", addr_err, 0);
      check("R11", "done pulses", done_cnt, 1);
      if (!ok) check("R10", "write data", int'(last_wr_data), 32'hF0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11", "reset done", int'(done), 0);
      check("R11", "reset rd_req", int'(rd_req), 0);
      check("R11", "reset wr_req", int'(wr_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // data-bit mode sweep
      for (int e = 0; e < 2; e++) begin
         for (int k = 0; k < 4; k++) begin
            fill_busy(e[0]); setb(k, e[0], 1'b0, 1'b0);
            run_case("R3", 1'b0, e[0], 8, 1'b0);
            fill_busy(e[0]); setb(k, e[0], 1'b1, 1'b1);
            run_case("R3", 1'b0, e[0], 8, 1'b0);
            fill_busy(e[0]); setb(k, ~e[0], 1'b0, 1'b1); setb(k + 1, e[0], 1'b0, 1'b0);
            run_case("R5", 1'b0, e[0], 8, 1'b0);
            fill_busy(e[0]); setb(k, ~e[0], 1'b0, 1'b1); setb(k + 1, ~e[0], 1'b0, 1'b0);
            run_case("R5", 1'b0, e[0], 8, 1'b0);
         end
      end
      // repeated busy reads before a match
      fill_busy(1'b1); setb(6, 1'b1, 1'b0, 1'b0);
      run_case("R4", 1'b0, 1'b1, 10, 1'b0);

      // toggle mode sweep
      for (int k = 0; k < 4; k++) begin
         fill_busy(1'b0); setb(2*k, 1'b1, 1'b1, 1'b0); setb(2*k + 1, 1'b1, 1'b1, 1'b0);
         run_case("R6", 1'b1, 1'b0, 8, 1'b0);
         fill_busy(1'b0); setb(2*k + 1, 1'b1, 1'b1, 1'b1);
         setb(2*k + 2, 1'b1, 1'b0, 1'b0); setb(2*k + 3, 1'b1, 1'b0, 1'b0);
         run_case("R8", 1'b1, 1'b0, 8, 1'b0);
         fill_busy(1'b0); setb(2*k + 1, 1'b1, 1'b1, 1'b1);
         run_case("R8", 1'b1, 1'b0, 8, 1'b0);
      end
      // pair straddling iterations must not be compared across pairs
      fill_busy(1'b0); setb(1, 1'b1, 1'b1, 1'b0); setb(2, 1'b1, 1'b1, 1'b0);
      setb(3, 1'b1, 1'b0, 1'b0); setb(4, 1'b1, 1'b0, 1'b0); setb(5, 1'b1, 1'b0, 1'b0);
      run_case("R7", 1'b1, 1'b0, 8, 1'b0);

      // iteration budget
      fill_busy(1'b0); run_case("R9", 1'b0, 1'b0, 3, 1'b0);
      fill_busy(1'b0); run_case("R9", 1'b0, 1'b0, 0, 1'b0);
      fill_busy(1'b1); run_case("R9", 1'b0, 1'b1, 1, 1'b0);
      fill_busy(1'b0); run_case("R9", 1'b1, 1'b0, 2, 1'b0);

      // start while busy is ignored
      fill_busy(1'b0); setb(5, 1'b0, 1'b0, 1'b0);
      run_case("R1", 1'b0, 1'b0, 8, 1'b1);
      fill_busy(1'b0); setb(6, 1'b1, 1'b0, 1'b0); setb(7, 1'b1, 1'b0, 1'b0);
      run_case("R1", 1'b1, 1'b0, 8, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule